// File: doc/BRIEF.md
# Thread-Block Admission Controller

This block sits between a kernel launch front end and a set of streaming-multiprocessor slots. Each incoming request names one thread block, by an identifier and a thread count. The controller places that block, whole, onto one multiprocessor that still has room for it.

Room is judged on two counts at once: how many blocks are resident on a multiprocessor, and how many threads are resident there. A block is admitted only when both counts stay within their limits after the block is added. When a block finishes, a release input names the multiprocessor and the thread count, and the controller returns that capacity.

Requests use a valid/ready handshake. A request with an illegal size is consumed and answered with an error pulse. A legal request waits, with ready low, until some multiprocessor can take it. Each grant reports the identifier, the chosen multiprocessor and the warp count of the block. The search for a multiprocessor is round-robin.

Top module: `blk_admit_ctrl`

## Requirements
- R1: An accepted legal request yields, one cycle after the accepting clock edge, a single-cycle `grant_valid` pulse. The pulse carries the request's identifier on `grant_id` and one multiprocessor index on `grant_sm`, so the block is never split.
- R2: No multiprocessor ever holds more than `MAX_BLK` (default 8) resident blocks. With 64-thread blocks on 4 multiprocessors, 32 grants fill the array and a 33rd request stalls.
- R3: No multiprocessor ever holds more than `MAX_THR` (default 1536) resident threads. Once a multiprocessor holds one 1024-thread block and one 512-thread block, it admits nothing more, not even a 1-thread block.
- R4: A request whose thread count is below 1 or above 1024 is accepted with ready high. It gives a one-cycle `req_error` pulse in the cycle after acceptance, gives no grant, and leaves both the counters and the round-robin pointer unchanged.
- R5: `grant_warps` equals the thread count divided by 32, rounded up. For example, 33 threads give 2 warps, 600 threads give 19 and 1024 threads give 32.
- R6: The multiprocessor search starts at the index one above the last granted multiprocessor, wrapping modulo the count. It skips every multiprocessor that cannot fit the block. After reset the first grant goes to index 0.
- R7: While a legal request is pending and no multiprocessor can fit it, `req_ready` is low. Fit is judged on the counters as they stand before any release in the same cycle, so ready rises in the cycle after a release that makes room.
- R8: A release lowers the named multiprocessor's block count by one and its thread count by `rel_threads` at the same clock edge. When a grant and a release hit the same multiprocessor at one edge, both changes apply.
- R9: `rst` is synchronous and active high. It clears all counters and makes the first search start at index 0. While `rst` is high, `req_ready` is low, and no grant or error is issued in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request is taken at this clock edge |
| req_id | input | ID_W | Block identifier |
| req_threads | input | THR_W | Threads in the block |
| grant_valid | output | 1 | Grant pulse |
| grant_id | output | ID_W | Identifier of the granted block |
| grant_sm | output | SM_W | Chosen multiprocessor |
| grant_warps | output | WARP_W | Warps occupied by the block |
| req_error | output | 1 | Illegal-size request was consumed |
| rel_valid | input | 1 | A resident block has finished |
| rel_sm | input | SM_W | Multiprocessor of the finished block |
| rel_threads | input | THR_W | Threads of the finished block |

## Verification
A grant and a release can land on the same multiprocessor at the same clock edge. The bench provokes this once every multiprocessor is full of threads. It first frees part of one multiprocessor. It then, at a single edge, grants a 512-thread block there while releasing a 1024-thread block from it. The netted result is judged through later requests: a 1024-thread block must still fit on that multiprocessor, and then a 1-thread block must stall. A lost grant or a lost release would break one of these two outcomes.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

  // Warps needed for a block: thread count over warp size, rounded up.
  function automatic int unsigned warps_for(input int unsigned threads,
                                            input int unsigned warp_size);
    return (threads + warp_size - 1) / warp_size;
  endfunction

  // Legal block size window.
  function automatic logic size_legal(input int unsigned threads,
                                      input int unsigned lo,
                                      input int unsigned hi);
    return (threads >= lo) && (threads <= hi);
  endfunction

endpackage

// File: rtl/blk_sm_slot.sv
module blk_sm_slot #(
  parameter int MAX_BLK = 8,
  parameter int MAX_THR = 1536,
  parameter int THR_W   = 11,
  parameter int BLK_W   = 4,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic             sub_en,
  input  logic [THR_W-1:0] req_thr,
  input  logic [THR_W-1:0] sub_thr,
  output logic             fits,
  output logic [BLK_W-1:0] blk_cnt,
  output logic [CNT_W-1:0] thr_cnt
);
  localparam int SUM_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

  logic [SUM_W-1:0] thr_sum;
  logic [BLK_W-1:0] blk_nxt;
  logic [CNT_W-1:0] thr_nxt;

  always_comb begin
    thr_sum = SUM_W'(thr_cnt) + SUM_W'(req_thr);
    fits    = (blk_cnt < BLK_W'(MAX_BLK)) && (thr_sum <= SUM_W'(MAX_THR));
  end

  // Grant and release net in one update.
  always_comb begin
    blk_nxt = blk_cnt;
    thr_nxt = thr_cnt;
    if (add_en) begin
      blk_nxt = blk_nxt + BLK_W'(1);
      thr_nxt = thr_nxt + CNT_W'(req_thr);
    end
    if (sub_en) begin
      blk_nxt = blk_nxt - BLK_W'(1);
      thr_nxt = thr_nxt - CNT_W'(sub_thr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_cnt <= '0;
      thr_cnt <= '0;
    end else begin
      blk_cnt <= blk_nxt;
      thr_cnt <= thr_nxt;
    end
  end
endmodule

// File: rtl/blk_rr_pick.sv
module blk_rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] last,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Walk from the farthest step to the nearest so the nearest candidate wins.
  always_comb begin
    found = 1'b0;
    idx   = last;
    for (int step = N; step >= 1; step--) begin
      int pos;
      pos = (int'(last) + step) % N;
      if (cand[pos]) begin
        found = 1'b1;
        idx   = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/blk_admit_ctrl.sv
module blk_admit_ctrl #(
  parameter int NUM_SM   = 4,
  parameter int MAX_BLK  = 8,
  parameter int MAX_THR  = 1536,
  parameter int MIN_SIZE = 1,
  parameter int MAX_SIZE = 1024,
  parameter int WARP_SZ  = 32,
  parameter int ID_W     = 16,
  parameter int THR_W    = $clog2(MAX_SIZE + 1),
  parameter int SM_W     = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  parameter int WARP_W   = $clog2((MAX_SIZE + WARP_SZ - 1) / WARP_SZ + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [THR_W-1:0]  req_threads,
  output logic              grant_valid,
  output logic [ID_W-1:0]   grant_id,
  output logic [SM_W-1:0]   grant_sm,
  output logic [WARP_W-1:0] grant_warps,
  output logic              req_error,
  input  logic              rel_valid,
  input  logic [SM_W-1:0]   rel_sm,
  input  logic [THR_W-1:0]  rel_threads
);
  import blk_admit_pkg::*;

  localparam int BLK_W = $clog2(MAX_BLK + 1);
  localparam int CNT_W = $clog2(MAX_THR + 1);

  // Named internal events for the checker.
  logic                        size_ok;
  logic                        any_fit;
  logic                        req_fire;
  logic                        take;
  logic                        reject;
  logic [SM_W-1:0]             pick_sm;
  logic [SM_W-1:0]             last_sm;
  logic [NUM_SM-1:0]           sm_fits;
  logic [NUM_SM-1:0][BLK_W-1:0] sm_blk_cnt;
  logic [NUM_SM-1:0][CNT_W-1:0] sm_thr_cnt;

  always_comb begin
    size_ok   = size_legal(int'(req_threads), MIN_SIZE, MAX_SIZE);
    req_ready = !rst && (!size_ok || any_fit);
    req_fire  = req_valid && req_ready;
    take      = req_fire && size_ok;
    reject    = req_fire && !size_ok;
  end

  for (genvar g = 0; g < NUM_SM; g++) begin : g_slot
    logic add_here;
    logic sub_here;
    assign add_here = take && (pick_sm == SM_W'(g));
    assign sub_here = rel_valid && (rel_sm == SM_W'(g));
    blk_sm_slot #(
      .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR),
      .THR_W(THR_W), .BLK_W(BLK_W), .CNT_W(CNT_W)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .add_en (add_here),
      .sub_en (sub_here),
      .req_thr(req_threads),
      .sub_thr(rel_threads),
      .fits   (sm_fits[g]),
      .blk_cnt(sm_blk_cnt[g]),
      .thr_cnt(sm_thr_cnt[g])
    );
  end

  blk_rr_pick #(.N(NUM_SM), .IDX_W(SM_W)) u_pick (
    .cand (sm_fits),
    .last (last_sm),
    .found(any_fit),
    .idx  (pick_sm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sm     <= SM_W'(NUM_SM - 1);
      grant_valid <= 1'b0;
      grant_id    <= '0;
      grant_sm    <= '0;
      grant_warps <= '0;
      req_error   <= 1'b0;
    end else begin
      grant_valid <= take;
      req_error   <= reject;
      if (take) begin
        last_sm     <= pick_sm;
        grant_id    <= req_id;
        grant_sm    <= pick_sm;
        grant_warps <= WARP_W'(warps_for(int'(req_threads), WARP_SZ));
      end
    end
  end
endmodule

// File: rtl/blk_admit_chk.sv
module blk_admit_chk #(
  parameter int NUM_SM   = 4,
  parameter int MAX_BLK  = 8,
  parameter int MAX_THR  = 1536,
  parameter int MIN_SIZE = 1,
  parameter int MAX_SIZE = 1024,
  parameter int THR_W    = 11,
  parameter int SM_W     = 2,
  parameter int BLK_W    = 4,
  parameter int CNT_W    = 11
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [THR_W-1:0]            req_threads,
  input logic                        grant_valid,
  input logic                        req_error,
  input logic                        take,
  input logic [SM_W-1:0]             pick_sm,
  input logic                        rel_valid,
  input logic [SM_W-1:0]             rel_sm,
  input logic [THR_W-1:0]            rel_threads,
  input logic [NUM_SM-1:0][BLK_W-1:0] sm_blk_cnt,
  input logic [NUM_SM-1:0][CNT_W-1:0] sm_thr_cnt
);
  for (genvar g = 0; g < NUM_SM; g++) begin : g_cap
    // R2
    blk_cap_chk: assert property (@(posedge clk) disable iff (rst)
      sm_blk_cnt[g] <= BLK_W'(MAX_BLK));
    // R3
    thr_cap_chk: assert property (@(posedge clk) disable iff (rst)
      sm_thr_cnt[g] <= CNT_W'(MAX_THR));
    // R8
    rel_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (rel_valid && rel_sm == SM_W'(g) && !(take && pick_sm == SM_W'(g)))
      |=> (sm_thr_cnt[g] == $past(sm_thr_cnt[g]) - CNT_W'($past(rel_threads))));
  end

  // R1
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_threads >= THR_W'(MIN_SIZE)
     && req_threads <= THR_W'(MAX_SIZE)) |=> grant_valid);

  // R4
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_threads < THR_W'(MIN_SIZE)
     || req_threads > THR_W'(MAX_SIZE))) |=> (req_error && !grant_valid));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!grant_valid && !req_error));

  // R1
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && req_error));
endmodule

bind blk_admit_ctrl blk_admit_chk #(
  .NUM_SM(NUM_SM), .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR),
  .MIN_SIZE(MIN_SIZE), .MAX_SIZE(MAX_SIZE), .THR_W(THR_W),
  .SM_W(SM_W), .BLK_W(BLK_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_threads(req_threads), .grant_valid(grant_valid), .req_error(req_error),
  .take(take), .pick_sm(pick_sm), .rel_valid(rel_valid), .rel_sm(rel_sm),
  .rel_threads(rel_threads), .sm_blk_cnt(sm_blk_cnt), .sm_thr_cnt(sm_thr_cnt)
);

// File: tb/blk_admit_ctrl_tb.sv
module blk_admit_ctrl_tb;
  localparam int ID_W = 16, THR_W = 11, SM_W = 2, WARP_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ID_W-1:0] req_id = '0;
  logic [THR_W-1:0] req_threads = '0;
  logic grant_valid;
  logic [ID_W-1:0] grant_id;
  logic [SM_W-1:0] grant_sm;
  logic [WARP_W-1:0] grant_warps;
  logic req_error;
  logic rel_valid = 1'b0;
  logic [SM_W-1:0] rel_sm = '0;
  logic [THR_W-1:0] rel_threads = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  blk_admit_ctrl u_dut (.*);

  // Captured results of one request.
  logic s_rdy, s_gv, s_err;
  logic [SM_W-1:0] s_sm;
  logic [WARP_W-1:0] s_w;
  logic [ID_W-1:0] s_id;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one request (optionally with a release at the same edge) and capture.
  task automatic send(input int thr, input int id, input logic rel,
                      input int rsm, input int rthr);
    @(negedge clk);
    req_valid   = 1'b1;
    req_threads = THR_W'(thr);
    req_id      = ID_W'(id);
    rel_valid   = rel;
    rel_sm      = SM_W'(rsm);
    rel_threads = THR_W'(rthr);
    #1 s_rdy = req_ready;
    @(negedge clk);
    s_gv = grant_valid; s_err = req_error; s_sm = grant_sm;
    s_w = grant_warps; s_id = grant_id;
    req_valid = 1'b0;
    rel_valid = 1'b0;
  endtask

  task automatic release_blk(input int rsm, input int rthr);
    @(negedge clk);
    rel_valid = 1'b1; rel_sm = SM_W'(rsm); rel_threads = THR_W'(rthr);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Vector: {threads[10:0], sm[1:0], warps[5:0], err}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {11'd256,  2'd0, 6'd8,  1'b0},
    {11'd100,  2'd1, 6'd4,  1'b0},
    {11'd0,    2'd0, 6'd0,  1'b1},
    {11'd1025, 2'd0, 6'd0,  1'b1},
    {11'd33,   2'd2, 6'd2,  1'b0},
    {11'd1024, 2'd3, 6'd32, 1'b0},
    {11'd1024, 2'd0, 6'd32, 1'b0},
    {11'd512,  2'd1, 6'd16, 1'b0},
    {11'd1500, 2'd0, 6'd0,  1'b1},
    {11'd300,  2'd2, 6'd10, 1'b0},
    {11'd600,  2'd1, 6'd19, 1'b0},
    {11'd32,   2'd2, 6'd1,  1'b0}
  };

  initial begin
    #2_000_000;
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9: request presented while in reset
    @(negedge clk);
    req_valid = 1'b1; req_threads = 11'd64; req_id = 16'hAAAA;
    #1 chk(req_ready == 1'b0, "R9 ready in reset", int'(req_ready), 0);
    @(negedge clk);
    chk(grant_valid == 1'b0 && req_error == 1'b0, "R9 no grant after reset edge",
        int'(grant_valid), 0);
    req_valid = 1'b0;
    rst = 1'b0;

    // Vector table: R1 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [10:0] thr;
      logic [1:0] esm;
      logic [5:0] ew;
      logic eerr;
      {thr, esm, ew, eerr} = VEC[i];
      send(int'(thr), 100 + i, 1'b0, 0, 0);
      chk(s_rdy == 1'b1, "R7 ready for fittable request", int'(s_rdy), 1);
      if (eerr) begin
        chk(s_err == 1'b1 && s_gv == 1'b0, "R4 illegal size flagged", int'(s_err), 1);
      end else begin
        chk(s_gv == 1'b1 && s_err == 1'b0, "R1 grant pulse", int'(s_gv), 1);
        chk(s_id == ID_W'(100 + i), "R1 grant id", int'(s_id), 100 + i);
        chk(s_sm == esm, "R6 round-robin choice", int'(s_sm), int'(esm));
        chk(s_w == ew, "R5 warp count", int'(s_w), int'(ew));
      end
    end
    @(negedge clk);
    chk(grant_valid == 1'b0, "R1 single-cycle pulse", int'(grant_valid), 0);

    // R2: block cap with 64-thread blocks
    do_reset();
    for (int i = 0; i < 32; i++) begin
      send(64, i, 1'b0, 0, 0);
      chk(s_gv == 1'b1 && s_sm == SM_W'(i % 4), "R2 fill grant", int'(s_sm), i % 4);
    end
    send(64, 99, 1'b0, 0, 0);
    chk(s_rdy == 1'b0, "R2 R7 stall at block cap", int'(s_rdy), 0);
    chk(s_gv == 1'b0, "R2 no grant at block cap", int'(s_gv), 0);
    release_blk(2, 64);
    send(64, 98, 1'b0, 0, 0);
    chk(s_gv == 1'b1 && s_sm == 2'd2, "R7 R6 grant after release skips full", int'(s_sm), 2);

    // R3: thread cap
    do_reset();
    for (int i = 0; i < 4; i++) begin
      send(1024, i, 1'b0, 0, 0);
      chk(s_gv == 1'b1 && s_sm == SM_W'(i), "R6 first grant from index 0", int'(s_sm), i);
    end
    for (int i = 0; i < 4; i++) begin
      send(512, 10 + i, 1'b0, 0, 0);
      chk(s_gv == 1'b1 && s_sm == SM_W'(i), "R3 fill to 1536", int'(s_sm), i);
    end
    send(1, 50, 1'b0, 0, 0);
    chk(s_rdy == 1'b0 && s_gv == 1'b0, "R3 thread cap stalls", int'(s_rdy), 0);
    // Illegal size is still consumed while full
    send(0, 51, 1'b0, 0, 0);
    chk(s_rdy == 1'b1 && s_err == 1'b1, "R4 error while full", int'(s_err), 1);

    // R8: release, then grant and release on same SM at one edge
    release_blk(1, 512);
    send(512, 60, 1'b1, 1, 1024);
    chk(s_gv == 1'b1 && s_sm == 2'd1, "R8 grant with same-edge release", int'(s_sm), 1);
    send(1024, 61, 1'b0, 0, 0);
    chk(s_gv == 1'b1 && s_sm == 2'd1, "R8 netted release applied", int'(s_gv), 1);
    send(1, 62, 1'b0, 0, 0);
    chk(s_rdy == 1'b0 && s_gv == 1'b0, "R8 netted grant applied", int'(s_rdy), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule